// File: doc/BRIEF.md
# Packet buffer allocation unit

This block hands out and takes back packet buffers for a network controller. A pool of 32 buffers is tracked by a one-bit-per-buffer free map. The host talks to it through a command strobe carrying a command code, a writable packet number register, and a read-only allocation result word. The result word has a FAILED flag at the top and the granted packet number at the bottom. An allocation that finds no free buffer waits. It completes by itself as soon as a release returns a buffer to the pool.

A release runs in the background for a fixed number of cycles, and a BUSY flag is high while it runs. The packet to release comes from one of two places. One variant takes the number offered at the head of the completion port. The other takes the number held in the packet number register. Every command takes effect when the strobe goes low, not when it goes high. A reset command returns the pool and all flags to their power-up state without a hardware reset.

Top module: `pba_alloc_unit`

## Requirements
- R1: A command acts on the trailing edge of `cmd_wr`. The code is captured while the strobe is high, and no output changes until the clock edge that samples the strobe low.
- R2: An accepted allocate sets FAILED to 1 and clears `alloc_int` at the trailing edge. When a buffer is granted one cycle later, FAILED goes to 0, the packet number is loaded and `alloc_int` goes to 1.
- R3: The lowest-numbered free buffer is granted first. A packet number is never granted twice without a release in between.
- R4: If no buffer is free, the allocate stays pending with FAILED at 1. It is granted on the clock edge after the one where a release frees a buffer.
- R5: Code 4 releases the packet number on `done_pkt`. Code 5 releases the number in the packet number register, which is written through `pnr_wr`/`pnr_wdata` and read on `pnr_q`.
- R6: A release holds `busy` high for exactly 4 cycles. The buffer returns to the pool on the cycle `busy` falls.
- R7: A release command issued while `busy` is high frees nothing and sets the sticky `rel_err` flag.
- R8: An allocate issued while another allocate is still pending is ignored and causes no second grant.
- R9: Code 2 (reset) marks every buffer free and cancels a pending allocate or a running release. It sets FAILED to 1 and the packet number to 0, clears the packet number register, and clears `alloc_int`, `busy` and `rel_err`.
- R10: After hardware reset, `arr_q` reads 8'h80, and `pnr_q`, `busy`, `alloc_int` and `rel_err` are all 0.
- R11: `arr_q` holds FAILED in bit 7, zero in bits 6:5 and the packet number in bits 4:0.
- R12: Command codes other than 1, 2, 4 and 5 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_code | input | 4 | Command code (1 alloc, 2 reset, 4 release head, 5 release register) |
| pnr_wr | input | 1 | Packet number register write strobe |
| pnr_wdata | input | 5 | Packet number register write data |
| done_pkt | input | 5 | Packet number at the head of the completion port |
| pnr_q | output | 5 | Packet number register contents |
| arr_q | output | 8 | Allocation result: FAILED, reserved zeros, packet number |
| busy | output | 1 | Release in progress |
| alloc_int | output | 1 | Allocation complete status |
| rel_err | output | 1 | Sticky flag: release issued while busy |

## Verification
Several properties are checked on every cycle. A BUSY rise must follow a strobe that was high and then low. BUSY cannot drop straight after it rises. A grant must clear FAILED and raise the interrupt. A pending allocate must persist while the pool is empty. A release attempt during BUSY must set the error flag. A reset command must restore FAILED, the packet number register and BUSY.

Only the bench scenarios can show the remaining behaviours. These are the order in which packet numbers are handed out, that no number is issued twice, the exact four-cycle BUSY window, and which source a release takes its number from. They also include the wake-up of a pending allocate after a release, and that ignored commands leave the pool unchanged. The bench checks these with a scoreboard of expected grants.

// File: rtl/pba_pkg.sv
package pba_pkg;
  typedef enum logic [3:0] {
    CMD_NOP      = 4'd0,
    CMD_ALLOC    = 4'd1,
    CMD_RESET    = 4'd2,
    CMD_REL_DONE = 4'd4,
    CMD_REL_PNR  = 4'd5
  } pba_cmd_e;
endpackage

// File: rtl/pba_cmd_edge.sv
module pba_cmd_edge #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic [CW-1:0] cmd_code,
  output logic          fire,
  output logic [CW-1:0] code
);
  logic wr_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_d <= 1'b0;
      code <= '0;
    end else begin
      wr_d <= cmd_wr;
      if (cmd_wr) code <= cmd_code;
    end
  end

  // trailing edge of the host strobe
  assign fire = wr_d & ~cmd_wr;
endmodule

// File: rtl/pba_release.sv
module pba_release #(
  parameter int NPKT = 32,
  parameter int PW   = 5,
  parameter int RCYC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          start,
  input  logic [PW-1:0] target,
  output logic          busy,
  output logic          free_pulse,
  output logic [PW-1:0] free_idx
);
  localparam int CNTW = $clog2(RCYC + 1);

  logic [CNTW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt      <= '0;
      free_idx <= '0;
    end else if (clr) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy     <= 1'b1;
      cnt      <= CNTW'(RCYC - 1);
      free_idx <= target;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assign free_pulse = busy && (cnt == '0) && !clr;

  p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && !clr) |=> busy);
  p_free_ends_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    free_pulse |=> !busy);
endmodule

// File: rtl/pba_free_map.sv
module pba_free_map #(
  parameter int NPKT = 32,
  parameter int PW   = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          set_en,
  input  logic [PW-1:0] set_idx,
  input  logic          grant_req,
  output logic          grant,
  output logic [PW-1:0] grant_idx,
  output logic          any_free
);
  logic [NPKT-1:0] free_q;
  logic [NPKT-1:0] free_nxt;

  function automatic logic [PW-1:0] lowest_free(input logic [NPKT-1:0] m);
    logic [PW-1:0] r;
    r = '0;
    for (int i = NPKT - 1; i >= 0; i--) begin
      if (m[i]) r = PW'(i);
    end
    return r;
  endfunction

  assign any_free  = |free_q;
  assign grant_idx = lowest_free(free_q);
  assign grant     = grant_req && any_free;

  always_comb begin
    free_nxt = free_q;
    if (set_en) free_nxt[set_idx]   = 1'b1;
    if (grant)  free_nxt[grant_idx] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   free_q <= '1;
    else if (clr) free_q <= '1;
    else          free_q <= free_nxt;
  end

  p_grant_taken_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !clr && !(set_en && set_idx == grant_idx)) |=> !free_q[$past(grant_idx)]);
endmodule

// File: rtl/pba_alloc_unit.sv
module pba_alloc_unit
  import pba_pkg::*;
#(
  parameter int NPKT = 32,
  parameter int PW   = 5,
  parameter int CW   = 4,
  parameter int ARW  = 8,
  parameter int RCYC = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_wr,
  input  logic [CW-1:0]  cmd_code,
  input  logic           pnr_wr,
  input  logic [PW-1:0]  pnr_wdata,
  input  logic [PW-1:0]  done_pkt,
  output logic [PW-1:0]  pnr_q,
  output logic [ARW-1:0] arr_q,
  output logic           busy,
  output logic           alloc_int,
  output logic           rel_err
);
  localparam int RSV = ARW - 1 - PW;

  logic          fire;
  logic [CW-1:0] code;
  logic          alloc_cmd, rel_cmd, rst_cmd;
  logic          alloc_accept, rel_accept;
  logic          pending, failed_q;
  logic [PW-1:0] pkt_q, rel_target;
  logic          grant, any_free, free_pulse;
  logic [PW-1:0] grant_idx, free_idx;

  pba_cmd_edge #(.CW(CW)) u_edge (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_code(cmd_code),
    .fire(fire), .code(code)
  );

  assign alloc_cmd    = fire && (code == CMD_ALLOC);
  assign rst_cmd      = fire && (code == CMD_RESET);
  assign rel_cmd      = fire && ((code == CMD_REL_DONE) || (code == CMD_REL_PNR));
  assign alloc_accept = alloc_cmd && !pending;
  assign rel_accept   = rel_cmd && !busy;
  assign rel_target   = (code == CMD_REL_DONE) ? done_pkt : pnr_q;

  pba_release #(.NPKT(NPKT), .PW(PW), .RCYC(RCYC)) u_rel (
    .clk(clk), .rst_n(rst_n), .clr(rst_cmd), .start(rel_accept),
    .target(rel_target), .busy(busy), .free_pulse(free_pulse), .free_idx(free_idx)
  );

  pba_free_map #(.NPKT(NPKT), .PW(PW)) u_map (
    .clk(clk), .rst_n(rst_n), .clr(rst_cmd), .set_en(free_pulse),
    .set_idx(free_idx), .grant_req(pending && !rst_cmd), .grant(grant),
    .grant_idx(grant_idx), .any_free(any_free)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending   <= 1'b0;
      failed_q  <= 1'b1;
      pkt_q     <= '0;
      alloc_int <= 1'b0;
      rel_err   <= 1'b0;
      pnr_q     <= '0;
    end else if (rst_cmd) begin
      pending   <= 1'b0;
      failed_q  <= 1'b1;
      pkt_q     <= '0;
      alloc_int <= 1'b0;
      rel_err   <= 1'b0;
      pnr_q     <= '0;
    end else begin
      if (pnr_wr) pnr_q <= pnr_wdata;
      if (rel_cmd && busy) rel_err <= 1'b1;
      if (alloc_accept) begin
        pending   <= 1'b1;
        failed_q  <= 1'b1;
        alloc_int <= 1'b0;
      end else if (grant) begin
        pending   <= 1'b0;
        failed_q  <= 1'b0;
        pkt_q     <= grant_idx;
        alloc_int <= 1'b1;
      end
    end
  end

  assign arr_q = {failed_q, {RSV{1'b0}}, pkt_q};

  p_trailing_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!$past(cmd_wr) && $past(cmd_wr, 2)));
  p_grant_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !rst_cmd) |=> (!arr_q[ARW-1] && alloc_int));
  p_pend_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !any_free && !rst_cmd) |=> (pending && arr_q[ARW-1]));
  p_ign_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_cmd && busy && !rst_cmd) |=> rel_err);
  p_rst_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_cmd |=> (arr_q[ARW-1] && pnr_q == '0 && !busy && !rel_err));
endmodule

// File: tb/pba_alloc_unit_tb_top.sv
module pba_alloc_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_wr = 1'b0;
  logic [3:0] cmd_code = 4'd0;
  logic       pnr_wr = 1'b0;
  logic [4:0] pnr_wdata = 5'd0;
  logic [4:0] done_pkt = 5'd0;
  logic [4:0] pnr_q;
  logic [7:0] arr_q;
  logic       busy, alloc_int, rel_err;

  int n_chk = 0;
  int n_err = 0;
  int exp_q[$];
  logic [31:0] held = '0;
  logic int_prev = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pba_alloc_unit dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_code(cmd_code),
    .pnr_wr(pnr_wr), .pnr_wdata(pnr_wdata), .done_pkt(done_pkt),
    .pnr_q(pnr_q), .arr_q(arr_q), .busy(busy), .alloc_int(alloc_int),
    .rel_err(rel_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [3:0] c);
    @(negedge clk); cmd_wr = 1'b1; cmd_code = c;
    @(negedge clk); cmd_wr = 1'b0;
  endtask

  task automatic write_pnr(input logic [4:0] v);
    @(negedge clk); pnr_wr = 1'b1; pnr_wdata = v;
    @(negedge clk); pnr_wr = 1'b0;
  endtask

  task automatic alloc_exp(input int pkt);
    exp_q.push_back(pkt);
    do_cmd(4'd1);
    repeat (3) @(negedge clk);
  endtask

  // monitor: pops the scoreboard on every new grant (R2, R3)
  always @(negedge clk) begin
    if (rst_n) begin
      if (alloc_int && !int_prev) begin
        if (exp_q.size() == 0) begin
          chk("R3 unexpected grant", {27'd0, arr_q[4:0]}, 32'hFFFF);
        end else begin
          automatic int e = exp_q.pop_front();
          chk("R3 grant order", {27'd0, arr_q[4:0]}, e);
          chk("R3 not already held", {31'd0, held[arr_q[4:0]]}, 0);
          chk("R11 arr format", {24'd0, arr_q[7:5]}, 0);
          held[arr_q[4:0]] = 1'b1;
        end
      end
      int_prev <= alloc_int;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 arr", arr_q, 8'h80);
    chk("R10 pnr", pnr_q, 0);
    chk("R10 busy/int/err", {busy, alloc_int, rel_err}, 0);

    // first grant with R1 timing
    exp_q.push_back(0);
    do_cmd(4'd1);
    chk("R1 no change before trailing edge", {alloc_int, arr_q}, 9'h080);
    @(negedge clk);
    chk("R2 pending failed", arr_q[7], 1);
    @(negedge clk);
    chk("R2 granted", {alloc_int, arr_q}, 9'h100);
    repeat (2) @(negedge clk);
    alloc_exp(1);
    alloc_exp(2);

    // R5/R6 release via register
    write_pnr(5'd1);
    chk("R5 pnr write", pnr_q, 1);
    do_cmd(4'd5);
    chk("R1 busy waits for trailing edge", busy, 0);
    cnt = 0;
    @(negedge clk);
    while (busy && cnt < 20) begin cnt++; @(negedge clk); end
    chk("R6 busy length", cnt, 4);
    held[1] = 1'b0;
    alloc_exp(1);

    // R5 release via completion port
    done_pkt = 5'd0;
    do_cmd(4'd4);
    repeat (6) @(negedge clk);
    held[0] = 1'b0;
    alloc_exp(0);

    for (int i = 3; i < 32; i++) alloc_exp(i);

    // R4 pending when empty
    do_cmd(4'd1);
    repeat (10) @(negedge clk);
    chk("R4 pending failed", {alloc_int, arr_q[7]}, 2'b01);
    do_cmd(4'd1); // R8 ignored while pending
    write_pnr(5'd7);
    held[7] = 1'b0;
    exp_q.push_back(7);
    do_cmd(4'd5);
    repeat (5) @(negedge clk);
    chk("R4 no grant as busy falls", {busy, alloc_int}, 0);
    @(negedge clk);
    chk("R4 grant next cycle", {alloc_int, arr_q}, 9'h107);
    repeat (8) @(negedge clk);
    chk("R8 second alloc ignored", {alloc_int, arr_q}, 9'h107);

    // R7 release while busy
    write_pnr(5'd3);
    done_pkt = 5'd4;
    do_cmd(4'd5);
    do_cmd(4'd4);
    repeat (6) @(negedge clk);
    chk("R7 rel_err", rel_err, 1);
    held[3] = 1'b0;
    alloc_exp(3);
    do_cmd(4'd1);
    repeat (8) @(negedge clk);
    chk("R7 packet 4 not freed", {alloc_int, arr_q[7]}, 2'b01);

    // R12 unknown code
    do_cmd(4'd3);
    repeat (4) @(negedge clk);
    chk("R12 code 3 no effect", {busy, rel_err, arr_q[7], pnr_q}, {3'b011, 5'd3});

    // R9 reset command
    do_cmd(4'd2);
    repeat (2) @(negedge clk);
    chk("R9 arr", arr_q, 8'h80);
    chk("R9 flags", {pnr_q, busy, alloc_int, rel_err}, 0);
    held = '0;
    alloc_exp(0);
    alloc_exp(1);
    repeat (4) @(negedge clk);
    chk("R2 scoreboard drained", exp_q.size(), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule